// File: doc/BRIEF.md
# Interrupt Acknowledge and Vector Source Selector

This block sits on the processor bus and watches for an interrupt acknowledge cycle. Such a cycle is marked by an all-ones function code while address strobe is low. The level being acknowledged is carried on three address lines. The block decides how the vector number for that level is supplied.

Each level has a capability bit that says whether the requesting device can return its own vector. If it can, the block pulls that device's active-low acknowledge line and passes the vector byte from the device to its vector output. If it cannot, the block pulls the active-low valid-peripheral line and produces the autovector number, which is 24 plus the level. Level 7 therefore maps to 31.

The response type and the level are chosen once, on the first cycle in which the strobe is seen low, and are held until the strobe rises. All outputs are registered, so each result appears one clock after the inputs that cause it.

Top module: `irq_ack_ctrl`

## Requirements
- R1: While reset is high, and on the first clock after it, every acknowledge line is high, the valid-peripheral line is high, the valid flag is 0 and the vector output is 0.
- R2: An acknowledge cycle is recognised only when the function code equals 3'b111 and address strobe is low. Any other function code, or a high strobe, produces no response.
- R3: An acknowledge cycle at level 0 (level lines 3'b000) produces no acknowledge, no valid-peripheral assertion and no valid flag.
- R4: For a level k from 1 to 7 whose capability bit (bit k-1) is 1, exactly one acknowledge line, bit k-1, goes low one clock after the strobe is sampled low.
- R5: In the device-vector case, the vector output equals the device vector byte that was sampled on the previous clock, for every clock of the cycle.
- R6: For a level k whose capability bit is 0, the valid-peripheral line goes low and the vector output equals 24+k. The device vector byte is ignored.
- R7: Whenever the valid flag is 1, exactly one of the eight response lines (seven acknowledges plus valid-peripheral) is low. When the flag is 0, none is low.
- R8: One clock after address strobe is sampled high, all response lines are high, the valid flag is 0 and the vector output is 0.
- R9: The response type and level are fixed when the cycle starts. Changes to the level lines or capability bits while the strobe stays low have no effect on which line is asserted.
- R10: After the strobe has been high for a single clock, a following acknowledge cycle is recognised and answered afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fc_i | input | 3 | Bus function code |
| lvl_i | input | 3 | Acknowledged level from address lines A3..A1 |
| as_n_i | input | 1 | Address strobe, active low |
| dev_cap_i | input | 7 | Bit k-1 is set when the level-k device supplies its own vector |
| dev_vec_i | input | 8 | Vector byte driven by the acknowledged device |
| iack_n_o | output | 7 | Per-level acknowledge, active low, bit k-1 for level k |
| vpa_n_o | output | 1 | Valid-peripheral request for autovectoring, active low |
| vec_o | output | 8 | Vector number for the current acknowledge |
| vec_valid_o | output | 1 | High while an acknowledge response is being driven |

## Verification
Every output of this block is due exactly one clock after the input values that produce it. Cycle start, the device vector byte and strobe release all follow that one-clock rule. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so exactly one rising edge separates stimulus and check. The freeze tests change the level and capability inputs in the same half-cycle in which the previous result is read. The next read then shows whether the held choice survived, and it also shows the new device byte, which must come through one clock late.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  typedef enum logic [1:0] {
    RESP_NONE   = 2'd0,
    RESP_DEVICE = 2'd1,
    RESP_AUTO   = 2'd2
  } resp_e;
endpackage

// File: rtl/irq_ack_detect.sv
module irq_ack_detect #(
  parameter int             FC_W    = 3,
  parameter int             LVL_W   = 3,
  parameter int             NUM_LVL = 7,
  parameter logic [FC_W-1:0] ACK_FC = '1
) (
  input  logic [FC_W-1:0]    fc_i,
  input  logic [LVL_W-1:0]   lvl_i,
  input  logic               as_n_i,
  input  logic [NUM_LVL-1:0] dev_cap_i,
  output logic               start_o,
  output logic               want_dev_o
);
  // A cycle is an acknowledge only with the special code, strobe low, nonzero level.
  always_comb begin
    start_o = (fc_i == ACK_FC) && !as_n_i && (lvl_i != '0);
  end

  // Pick the capability bit for the presented level.
  always_comb begin
    want_dev_o = 1'b0;
    for (int k = 1; k <= NUM_LVL; k++) begin
      if (lvl_i == LVL_W'(k)) want_dev_o = dev_cap_i[k-1];
    end
  end
endmodule

// File: rtl/irq_ack_track.sv
module irq_ack_track
  import irq_ack_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             as_n_i,
  input  logic             start_i,
  input  logic             want_dev_i,
  input  logic [LVL_W-1:0] lvl_i,
  output resp_e            nxt_mode_o,
  output logic [LVL_W-1:0] nxt_lvl_o
);
  resp_e            mode_q;
  logic [LVL_W-1:0] lvl_q;

  // Choice is made on the first strobe-low cycle and held until the strobe rises.
  always_comb begin
    nxt_mode_o = mode_q;
    nxt_lvl_o  = lvl_q;
    if (as_n_i) begin
      nxt_mode_o = RESP_NONE;
      nxt_lvl_o  = '0;
    end else if (mode_q == RESP_NONE && start_i) begin
      nxt_mode_o = want_dev_i ? RESP_DEVICE : RESP_AUTO;
      nxt_lvl_o  = lvl_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= RESP_NONE;
      lvl_q  <= '0;
    end else begin
      mode_q <= nxt_mode_o;
      lvl_q  <= nxt_lvl_o;
    end
  end
endmodule

// File: rtl/irq_ack_drive.sv
module irq_ack_drive
  import irq_ack_pkg::*;
#(
  parameter int LVL_W     = 3,
  parameter int NUM_LVL   = 7,
  parameter int VEC_W     = 8,
  parameter int AUTO_BASE = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  resp_e              nxt_mode_i,
  input  logic [LVL_W-1:0]   nxt_lvl_i,
  input  logic [VEC_W-1:0]   dev_vec_i,
  output logic [NUM_LVL-1:0] iack_n_o,
  output logic               vpa_n_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vec_valid_o
);
  logic [NUM_LVL-1:0] iack_n_d;
  logic [VEC_W-1:0]   vec_d;

  // One acknowledge strobe per level.
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_ack
    assign iack_n_d[g] = !((nxt_mode_i == RESP_DEVICE) && (nxt_lvl_i == LVL_W'(g + 1)));
  end

  always_comb begin
    unique case (nxt_mode_i)
      RESP_DEVICE: vec_d = dev_vec_i;
      RESP_AUTO:   vec_d = VEC_W'(AUTO_BASE) + VEC_W'(nxt_lvl_i);
      default:     vec_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iack_n_o    <= '1;
      vpa_n_o     <= 1'b1;
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      iack_n_o    <= iack_n_d;
      vpa_n_o     <= !(nxt_mode_i == RESP_AUTO);
      vec_o       <= vec_d;
      vec_valid_o <= (nxt_mode_i != RESP_NONE);
    end
  end
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_ack_pkg::*;
#(
  parameter int              FC_W      = 3,
  parameter int              LVL_W     = 3,
  parameter int              VEC_W     = 8,
  parameter int              AUTO_BASE = 24,
  parameter logic [FC_W-1:0] ACK_FC    = '1,
  localparam int             NUM_LVL   = (1 << LVL_W) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FC_W-1:0]    fc_i,
  input  logic [LVL_W-1:0]   lvl_i,
  input  logic               as_n_i,
  input  logic [NUM_LVL-1:0] dev_cap_i,
  input  logic [VEC_W-1:0]   dev_vec_i,
  output logic [NUM_LVL-1:0] iack_n_o,
  output logic               vpa_n_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vec_valid_o
);
  logic             start;
  logic             want_dev;
  resp_e            nxt_mode;
  logic [LVL_W-1:0] nxt_lvl;

  irq_ack_detect #(
    .FC_W(FC_W), .LVL_W(LVL_W), .NUM_LVL(NUM_LVL), .ACK_FC(ACK_FC)
  ) u_detect (
    .fc_i(fc_i), .lvl_i(lvl_i), .as_n_i(as_n_i), .dev_cap_i(dev_cap_i),
    .start_o(start), .want_dev_o(want_dev)
  );

  irq_ack_track #(.LVL_W(LVL_W)) u_track (
    .clk(clk), .rst(rst), .as_n_i(as_n_i), .start_i(start),
    .want_dev_i(want_dev), .lvl_i(lvl_i),
    .nxt_mode_o(nxt_mode), .nxt_lvl_o(nxt_lvl)
  );

  irq_ack_drive #(
    .LVL_W(LVL_W), .NUM_LVL(NUM_LVL), .VEC_W(VEC_W), .AUTO_BASE(AUTO_BASE)
  ) u_drive (
    .clk(clk), .rst(rst), .nxt_mode_i(nxt_mode), .nxt_lvl_i(nxt_lvl),
    .dev_vec_i(dev_vec_i), .iack_n_o(iack_n_o), .vpa_n_o(vpa_n_o),
    .vec_o(vec_o), .vec_valid_o(vec_valid_o)
  );
endmodule

// File: rtl/irq_ack_checker.sv
module irq_ack_checker #(
  parameter int              FC_W      = 3,
  parameter int              LVL_W     = 3,
  parameter int              VEC_W     = 8,
  parameter int              AUTO_BASE = 24,
  parameter logic [FC_W-1:0] ACK_FC    = '1,
  parameter int              NUM_LVL   = 7
) (
  input logic               clk,
  input logic               rst,
  input logic [FC_W-1:0]    fc_i,
  input logic [LVL_W-1:0]   lvl_i,
  input logic               as_n_i,
  input logic [NUM_LVL-1:0] iack_n_o,
  input logic               vpa_n_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic               vec_valid_o
);
  a_r7_single_response: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |-> (($countones(~iack_n_o) + $countones(~vpa_n_o)) == 1));

  a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !vec_valid_o |-> (&iack_n_o && vpa_n_o));

  a_r4_one_ack_line: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~iack_n_o));

  a_r2_needs_ack_code: assert property (@(posedge clk) disable iff (rst)
    (!vec_valid_o && (fc_i != ACK_FC || as_n_i)) |=> !vec_valid_o);

  a_r3_level_zero: assert property (@(posedge clk) disable iff (rst)
    (!vec_valid_o && lvl_i == '0) |=> !vec_valid_o);

  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    as_n_i |=> (!vec_valid_o && &iack_n_o && vpa_n_o));

  a_r9_held_choice: assert property (@(posedge clk) disable iff (rst)
    (vec_valid_o && !as_n_i) |=> ($stable(iack_n_o) && $stable(vpa_n_o)));

  a_r6_auto_range: assert property (@(posedge clk) disable iff (rst)
    !vpa_n_o |-> (int'(vec_o) > AUTO_BASE && int'(vec_o) <= AUTO_BASE + NUM_LVL));
endmodule

bind irq_ack_ctrl irq_ack_checker #(
  .FC_W(FC_W), .LVL_W(LVL_W), .VEC_W(VEC_W), .AUTO_BASE(AUTO_BASE),
  .ACK_FC(ACK_FC), .NUM_LVL(NUM_LVL)
) u_checker (
  .clk(clk), .rst(rst), .fc_i(fc_i), .lvl_i(lvl_i), .as_n_i(as_n_i),
  .iack_n_o(iack_n_o), .vpa_n_o(vpa_n_o), .vec_o(vec_o),
  .vec_valid_o(vec_valid_o)
);

// File: tb/test_irq_ack_ctrl.sv
`timescale 1ns/1ps
module test_irq_ack_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] fc_i = 3'd0;
  logic [2:0] lvl_i = 3'd0;
  logic       as_n_i = 1'b1;
  logic [6:0] dev_cap_i = 7'h00;
  logic [7:0] dev_vec_i = 8'h00;
  logic [6:0] iack_n_o;
  logic       vpa_n_o;
  logic [7:0] vec_o;
  logic       vec_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_ack_ctrl i_irq_ack_ctrl (
    .clk(clk), .rst(rst), .fc_i(fc_i), .lvl_i(lvl_i), .as_n_i(as_n_i),
    .dev_cap_i(dev_cap_i), .dev_vec_i(dev_vec_i), .iack_n_o(iack_n_o),
    .vpa_n_o(vpa_n_o), .vec_o(vec_o), .vec_valid_o(vec_valid_o)
  );

  typedef struct packed {
    logic [2:0] fc;
    logic [2:0] lvl;
    logic [6:0] cap;
    logic [7:0] dvec;
    logic [6:0] e_iack;
    logic       e_vpa;
    logic [7:0] e_vec;
    logic       e_val;
  } row_t;

  localparam int NROW = 11;
  localparam row_t TBL [NROW] = '{
    '{3'd7, 3'd2, 7'h00, 8'h5A, 7'h7F, 1'b0, 8'd26, 1'b1},  // R6 level 2 auto
    '{3'd7, 3'd5, 7'h10, 8'hA5, 7'h6F, 1'b1, 8'hA5, 1'b1},  // R4 R5 level 5 device
    '{3'd7, 3'd1, 7'h00, 8'hFF, 7'h7F, 1'b0, 8'd25, 1'b1},  // R6 lowest auto
    '{3'd7, 3'd7, 7'h00, 8'h33, 7'h7F, 1'b0, 8'd31, 1'b1},  // R6 highest auto
    '{3'd7, 3'd7, 7'h40, 8'h40, 7'h3F, 1'b1, 8'h40, 1'b1},  // R4 level 7 device
    '{3'd6, 3'd3, 7'h7F, 8'h12, 7'h7F, 1'b1, 8'h00, 1'b0},  // R2 code 6
    '{3'd5, 3'd4, 7'h00, 8'h12, 7'h7F, 1'b1, 8'h00, 1'b0},  // R2 code 5
    '{3'd7, 3'd0, 7'h7F, 8'h77, 7'h7F, 1'b1, 8'h00, 1'b0},  // R3 level 0
    '{3'd7, 3'd3, 7'h7B, 8'h99, 7'h7F, 1'b0, 8'd27, 1'b1},  // R6 cap bit clear among set
    '{3'd7, 3'd1, 7'h01, 8'h00, 7'h7E, 1'b1, 8'h00, 1'b1},  // R4 R5 device vector zero
    '{3'd3, 3'd6, 7'h7F, 8'h44, 7'h7F, 1'b1, 8'h00, 1'b0}   // R2 code 3
  };

  task automatic chk(input string req, input logic [6:0] e_iack, input logic e_vpa,
                     input logic [7:0] e_vec, input logic e_val);
    checks++;
    if (iack_n_o !== e_iack || vpa_n_o !== e_vpa || vec_o !== e_vec || vec_valid_o !== e_val) begin
      errors++;
      $display("FAIL %s: got iack=%h vpa=%b vec=%h val=%b, expected iack=%h vpa=%b vec=%h val=%b",
               req, iack_n_o, vpa_n_o, vec_o, vec_valid_o, e_iack, e_vpa, e_vec, e_val);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset", 7'h7F, 1'b1, 8'h00, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", 7'h7F, 1'b1, 8'h00, 1'b0);

    for (int i = 0; i < NROW; i++) begin
      fc_i = TBL[i].fc; lvl_i = TBL[i].lvl; dev_cap_i = TBL[i].cap;
      dev_vec_i = TBL[i].dvec; as_n_i = 1'b0;
      @(negedge clk);
      chk($sformatf("R7 row %0d", i), TBL[i].e_iack, TBL[i].e_vpa, TBL[i].e_vec, TBL[i].e_val);
      as_n_i = 1'b1;
      @(negedge clk);
      chk($sformatf("R8 release row %0d", i), 7'h7F, 1'b1, 8'h00, 1'b0);
    end

    // R2: right code but strobe high
    fc_i = 3'd7; lvl_i = 3'd4; dev_cap_i = 7'h7F; as_n_i = 1'b1;
    @(negedge clk);
    chk("R2 strobe high", 7'h7F, 1'b1, 8'h00, 1'b0);

    // R9: choice frozen, R5: device byte tracks one clock late
    lvl_i = 3'd4; dev_cap_i = 7'h7F; dev_vec_i = 8'h11; as_n_i = 1'b0;
    @(negedge clk);
    chk("R9 start device", 7'h77, 1'b1, 8'h11, 1'b1);
    lvl_i = 3'd6; dev_cap_i = 7'h00; dev_vec_i = 8'h22;
    @(negedge clk);
    chk("R9 held despite change", 7'h77, 1'b1, 8'h22, 1'b1);
    as_n_i = 1'b1;
    @(negedge clk);
    chk("R8 release after hold", 7'h7F, 1'b1, 8'h00, 1'b0);

    // R10: new cycle after one high clock
    lvl_i = 3'd3; dev_cap_i = 7'h00; as_n_i = 1'b0;
    @(negedge clk);
    chk("R10 back to back", 7'h7F, 1'b0, 8'd27, 1'b1);

    // R9: auto cycle holds against a capability set mid-cycle
    lvl_i = 3'd2; dev_cap_i = 7'h7F; dev_vec_i = 8'h66;
    @(negedge clk);
    chk("R9 held auto", 7'h7F, 1'b0, 8'd27, 1'b1);

    // R1: reset during an active cycle
    rst = 1'b1; as_n_i = 1'b1;
    @(negedge clk);
    chk("R1 reset mid cycle", 7'h7F, 1'b1, 8'h00, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule